// File: doc/BRIEF.md
# Serial Asynchronous Frame Receiver

This block samples an asynchronous serial input line and rebuilds non-return-to-zero characters from it. Each character is one low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit and a stop bit. The block uses the same baud rate, data length and parity setting as the companion transmitter, but it always checks exactly one stop bit, whatever stop-bit count the transmitter is set to send. Each bit lasts 16 ticks of an internal baud tick. That tick fires once every `baud_div + 1` clock cycles.

The bit value is the majority of three samples taken around the middle of the bit, and any disagreement among the three raises a noise flag. A received character goes into a one-word holding register and raises `rx_ready`. The framing, parity and noise flags of that character are held next to it until the consumer pulses `rd_ack`. When a new character completes while the held one is still unread, the overrun flag is set and the old word is kept. With address detection on, the most significant data bit marks a character as an address, and characters without that mark are dropped. Pulling `enable` low empties the holding register, clears every flag and forces the receiver idle.

The frame state machine has five states. In `ST_IDLE` the receiver waits for a low line on a baud tick, which moves it to `ST_START`. In `ST_START`, a high mid-bit vote is a false start and returns to `ST_IDLE`. Otherwise the end of the bit moves it to `ST_DATA`. After the last data bit, `ST_DATA` moves to `ST_PARITY` when parity is enabled and to `ST_STOP` otherwise. `ST_PARITY` moves to `ST_STOP` at the end of its bit. `ST_STOP` returns to `ST_IDLE` as soon as the stop bit has been voted at mid-bit. From any state, `enable` low forces `ST_IDLE`.

Top module: `urx_core`

## Requirements
- R1: After reset, `rx_idle` is 1, `rx_ready` is 0, all four error flags are 0 and `rx_data` is 0.
- R2: With `nine_bits`=0, 8 data bits are taken least significant first and presented on `rx_data[7:0]`, with `rx_data[8]`=0, and `rx_ready` rises.
- R3: With `nine_bits`=1, 9 data bits are taken least significant first and presented on `rx_data[8:0]`.
- R4: With `par_en`=1, one parity bit follows the data. It should make the count of ones over data and parity even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets `err_parity` with the word.
- R5: Exactly one stop bit is checked. A stop bit voted low sets `err_frame`, and the word is still delivered.
- R6: Each bit is the majority of three samples at ticks 7, 8 and 9 of the 16-tick bit. A single disturbed sample does not change the bit, and any disagreement in a frame sets `err_noise`.
- R7: A start bit that votes high at mid-bit is a false start. No word is delivered and the receiver returns to idle.
- R8: A character completing while `rx_ready` is 1 and not acknowledged sets `err_overrun` and leaves `rx_data` and its flags unchanged.
- R9: With `addr_det`=1, a character whose address bit is 0 is discarded without changing any output. The address bit is `rx_data[8]` in 9-bit mode and `rx_data[7]` in 8-bit mode.
- R10: `rx_idle` is 0 from start-bit detection until the stop bit has been voted.
- R11: `enable`=0 clears `rx_data`, `rx_ready` and all error flags, sets `rx_idle` and abandons any frame in progress.
- R12: A one-cycle `rd_ack` clears `rx_ready`, `err_frame`, `err_parity`, `err_noise` and `err_overrun`.
- R13: One bit lasts 16 × (`baud_div` + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver on; low clears buffer and flags |
| rx | input | 1 | Serial input line, idle high |
| nine_bits | input | 1 | 1 = 9 data bits, 0 = 8 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| addr_det | input | 1 | Drop characters whose address bit is 0 |
| baud_div | input | DIVW | Baud tick every baud_div+1 clocks |
| rd_ack | input | 1 | Consume held word and flags |
| rx_data | output | 9 | Held received word |
| rx_ready | output | 1 | Receive flag: held word is unread |
| err_frame | output | 1 | Stop bit voted low |
| err_parity | output | 1 | Parity mismatch |
| err_noise | output | 1 | Sample disagreement within the frame |
| err_overrun | output | 1 | Character lost because the buffer was full |
| rx_idle | output | 1 | No frame in progress |

## Verification
On every cycle, the assertions check the following. Disabling the block clears every flag and idles it. An overrun never alters the held word. `rx_ready` only rises after a stop-bit vote. No error flag exists without a held word. A false start always returns to idle. The bench scenarios cover what only whole serial waveforms can show: bit order and width, parity polarity, majority voting against a single glitched sample, address filtering, and bit timing under different baud dividers.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              frame_bad;
        logic              parity_bad;
        logic              noisy;
    } rx_result_t;
endpackage

// File: rtl/urx_tick.sv
module urx_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] baud_div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= baud_div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       line,
    input  logic       nine_bits,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       done,
    output rx_result_t result,
    output logic       busy
);
    localparam int OSW = $clog2(OVS);
    localparam logic [OSW-1:0] MID   = OSW'(OVS / 2);
    localparam logic [OSW-1:0] EARLY = OSW'(OVS / 2 - 1);
    localparam logic [OSW-1:0] LATE  = OSW'(OVS / 2 + 1);
    localparam logic [OSW-1:0] LAST  = OSW'(OVS - 1);

    rx_state_e         state, nxt;
    logic [OSW-1:0]    os;
    logic [3:0]        bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              samp_a, samp_b;
    logic              noise_acc;
    logic              par_bit;
    logic              bit_val, split, mid_hit, bit_end, last_data;

    assign bit_val   = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);
    assign split     = !((samp_a == samp_b) && (samp_b == line));
    assign mid_hit   = tick && (os == LATE);
    assign bit_end   = tick && (os == LAST);
    assign last_data = (bit_cnt == (nine_bits ? 4'd8 : 4'd7));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  begin
                if (mid_hit && bit_val) nxt = ST_IDLE;
                else if (bit_end)       nxt = ST_DATA;
            end
            ST_DATA:   if (bit_end && last_data) nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) nxt = ST_STOP;
            ST_STOP:   if (mid_hit) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (!run) state <= ST_IDLE;
        else           state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os        <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            samp_a    <= 1'b1;
            samp_b    <= 1'b1;
            noise_acc <= 1'b0;
            par_bit   <= 1'b0;
        end else if (!run) begin
            os        <= '0;
            bit_cnt   <= '0;
            noise_acc <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                os        <= '0;
                bit_cnt   <= '0;
                noise_acc <= 1'b0;
            end else if (tick) begin
                os <= (os == LAST) ? '0 : os + 1'b1;
            end
            if (tick && os == EARLY) samp_a <= line;
            if (tick && os == MID)   samp_b <= line;
            if (state != ST_IDLE && mid_hit) noise_acc <= noise_acc | split;
            if (state == ST_DATA && mid_hit) shreg   <= {bit_val, shreg[WORD_W-1:1]};
            if (state == ST_DATA && bit_end) bit_cnt <= bit_cnt + 1'b1;
            if (state == ST_PARITY && mid_hit) par_bit <= bit_val;
        end
    end

    always_comb begin
        done              = (state == ST_STOP) && mid_hit;
        result.word       = nine_bits ? shreg : {1'b0, shreg[WORD_W-1:1]};
        result.frame_bad  = !bit_val;
        result.parity_bad = par_en && (par_bit != ((^result.word) ^ par_odd));
        result.noisy      = noise_acc | split;
        busy              = (state != ST_IDLE);
    end

    // R7: a high mid-start vote abandons the frame
    assert_false_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_START && mid_hit && bit_val) |=> (state == ST_IDLE))
        else $error("false start not abandoned");
endmodule

// File: rtl/urx_core.sv
module urx_core
    import urx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DIVW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            rx,
    input  logic            nine_bits,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            addr_det,
    input  logic [DIVW-1:0] baud_div,
    input  logic            rd_ack,
    output logic [8:0]      rx_data,
    output logic            rx_ready,
    output logic            err_frame,
    output logic            err_parity,
    output logic            err_noise,
    output logic            err_overrun,
    output logic            rx_idle
);
    logic       tick, line, done, busy, accept;
    rx_result_t res;

    urx_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(enable), .baud_div(baud_div), .tick(tick)
    );

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx), .dout(line)
    );

    urx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick), .line(line),
        .nine_bits(nine_bits), .par_en(par_en), .par_odd(par_odd),
        .done(done), .result(res), .busy(busy)
    );

    assign accept  = !addr_det || (nine_bits ? res.word[8] : res.word[7]);
    assign rx_idle = !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_noise   <= 1'b0;
            err_overrun <= 1'b0;
        end else if (!enable) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_noise   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (rd_ack) begin
                rx_ready    <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
                err_noise   <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (done && accept) begin
                if (rx_ready && !rd_ack) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data    <= res.word;
                    rx_ready   <= 1'b1;
                    err_frame  <= res.frame_bad;
                    err_parity <= res.parity_bad;
                    err_noise  <= res.noisy;
                end
            end
        end
    end

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rx_idle && !rx_ready && !err_overrun && !err_frame &&
                     !err_parity && !err_noise && rx_data == '0))
        else $error("disable did not clear state");

    assert_overrun_keeps_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && done && accept && rx_ready && !rd_ack) |=> (err_overrun && $stable(rx_data)))
        else $error("overrun altered held word");

    assert_ready_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(done))
        else $error("ready rose without a completed frame");

    assert_flags_need_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame || err_parity || err_noise || err_overrun) |-> rx_ready)
        else $error("error flag without a held word");
endmodule

// File: tb/sim_urx_core.sv
module sim_urx_core;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst_n, enable, rx, nine_bits, par_en, par_odd, addr_det, rd_ack;
    logic [7:0] baud_div;
    logic [8:0] rx_data;
    logic       rx_ready, err_frame, err_parity, err_noise, err_overrun, rx_idle;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    urx_core u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx(rx), .nine_bits(nine_bits),
        .par_en(par_en), .par_odd(par_odd), .addr_det(addr_det), .baud_div(baud_div),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_parity(err_parity), .err_noise(err_noise), .err_overrun(err_overrun),
        .rx_idle(rx_idle)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_word(input logic [8:0] d, input bit nine);
        return nine ? d : {1'b0, d[7:0]};
    endfunction

    function automatic logic exp_par(input logic [8:0] d, input bit nine, input bit odd);
        return (^exp_word(d, nine)) ^ odd;
    endfunction

    task automatic drive_bit(input logic v, input int len, input bit glitch);
        rx = v;
        for (int c = 1; c <= len; c++) begin
            if (glitch && c == 10) rx = ~v;
            @(negedge clk);
            if (glitch && c == 10) rx = v;
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                              input int glitch_at);
        int len;
        int nb;
        len = OVS * (int'(baud_div) + 1);
        nb  = nine_bits ? 9 : 8;
        drive_bit(1'b0, len, glitch_at == 0);
        for (int i = 0; i < nb; i++) drive_bit(d[i], len, glitch_at == i + 1);
        if (par_en) drive_bit(exp_par(d, nine_bits, par_odd) ^ bad_par, len, 1'b0);
        drive_bit(!bad_stop, len, 1'b0);
        rx = 1'b1;
    endtask

    task automatic settle();
        repeat (2 * OVS * (int'(baud_div) + 1)) @(negedge clk);
    endtask

    task automatic read_word();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_word(input string req, input logic [8:0] d, input bit fe,
                               input bit pe, input bit ne, input bit ov);
        check_eq({req, " ready"},   int'(rx_ready), 1);
        check_eq({req, " data"},    int'(rx_data), int'(d));
        check_eq({req, " frame"},   int'(err_frame), int'(fe));
        check_eq({req, " parity"},  int'(err_parity), int'(pe));
        check_eq({req, " noise"},   int'(err_noise), int'(ne));
        check_eq({req, " overrun"}, int'(err_overrun), int'(ov));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] d;
        bit bp, bs;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; enable = 1'b1; rx = 1'b1; nine_bits = 1'b0; par_en = 1'b0;
        par_odd = 1'b0; addr_det = 1'b0; rd_ack = 1'b0; baud_div = 8'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 idle", int'(rx_idle), 1);
        check_eq("R1 ready", int'(rx_ready), 0);
        check_eq("R1 flags", int'({err_frame, err_parity, err_noise, err_overrun}), 0);
        check_eq("R1 data", int'(rx_data), 0);

        // R2 8-bit LSB first
        send_frame(9'h0A5, 0, 0, -1); settle();
        expect_word("R2", 9'h0A5, 0, 0, 0, 0);
        // R12 acknowledge clears
        read_word();
        check_eq("R12 ready cleared", int'(rx_ready), 0);

        // R3 9-bit
        nine_bits = 1'b1;
        send_frame(9'h1C3, 0, 0, -1); settle();
        expect_word("R3", 9'h1C3, 0, 0, 0, 0); read_word();

        // R4 parity even / odd / wrong
        nine_bits = 1'b0; par_en = 1'b1; par_odd = 1'b0;
        send_frame(9'h037, 0, 0, -1); settle();
        expect_word("R4 even", 9'h037, 0, 0, 0, 0); read_word();
        par_odd = 1'b1;
        send_frame(9'h037, 0, 0, -1); settle();
        expect_word("R4 odd", 9'h037, 0, 0, 0, 0); read_word();
        send_frame(9'h0E1, 1, 0, -1); settle();
        expect_word("R4 bad", 9'h0E1, 0, 1, 0, 0); read_word();
        check_eq("R12 parity cleared", int'(err_parity), 0);
        par_en = 1'b0;

        // R5 stop bit low
        send_frame(9'h05A, 0, 1, -1); settle();
        expect_word("R5", 9'h05A, 1, 0, 0, 0); read_word();

        // R6 glitch on the middle sample of data bit 3
        send_frame(9'h0F0, 0, 0, 4); settle();
        expect_word("R6", 9'h0F0, 0, 0, 1, 0); read_word();

        // R7 false start
        rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
        settle();
        check_eq("R7 no word", int'(rx_ready), 0);
        check_eq("R7 idle", int'(rx_idle), 1);

        // R8 overrun
        send_frame(9'h011, 0, 0, -1); settle();
        send_frame(9'h022, 0, 0, -1); settle();
        expect_word("R8", 9'h011, 0, 0, 0, 1);
        read_word();
        check_eq("R12 overrun cleared", int'(err_overrun), 0);

        // R9 address detection
        addr_det = 1'b1;
        send_frame(9'h012, 0, 0, -1); settle();
        check_eq("R9 drop 8-bit", int'(rx_ready), 0);
        send_frame(9'h092, 0, 0, -1); settle();
        expect_word("R9 keep 8-bit", 9'h092, 0, 0, 0, 0); read_word();
        nine_bits = 1'b1;
        send_frame(9'h055, 0, 0, -1); settle();
        check_eq("R9 drop 9-bit", int'(rx_ready), 0);
        check_eq("R9 data unchanged", int'(rx_data), 9'h092);
        send_frame(9'h1AA, 0, 0, -1); settle();
        expect_word("R9 keep 9-bit", 9'h1AA, 0, 0, 0, 0); read_word();
        addr_det = 1'b0; nine_bits = 1'b0;

        // R10 idle low inside a frame
        fork
            send_frame(9'h066, 0, 0, -1);
            begin
                repeat (40) @(negedge clk);
                check_eq("R10 busy mid-frame", int'(rx_idle), 0);
            end
        join
        settle();
        check_eq("R10 idle after stop", int'(rx_idle), 1);

        // R11 disable with a held word
        enable = 1'b0; @(negedge clk);
        check_eq("R11 ready", int'(rx_ready), 0);
        check_eq("R11 data", int'(rx_data), 0);
        check_eq("R11 idle", int'(rx_idle), 1);
        enable = 1'b1;
        // R11 disable mid-frame
        fork
            send_frame(9'h0C3, 0, 0, -1);
            begin
                repeat (60) @(negedge clk);
                enable = 1'b0;
                @(negedge clk);
                check_eq("R11 idle mid-frame", int'(rx_idle), 1);
            end
        join
        enable = 1'b1; settle();
        check_eq("R11 frame abandoned", int'(rx_ready), 0);

        // R13 slower baud
        baud_div = 8'd2;
        send_frame(9'h03C, 0, 0, -1); settle();
        expect_word("R13", 9'h03C, 0, 0, 0, 0); read_word();

        // Random frames over formats and dividers (R2 R3 R4 R5 R13)
        for (int k = 0; k < 30; k++) begin
            nine_bits = 1'($urandom_range(0, 1));
            par_en    = 1'($urandom_range(0, 1));
            par_odd   = 1'($urandom_range(0, 1));
            baud_div  = 8'($urandom_range(0, 2));
            d         = 9'($urandom_range(0, 511));
            bp        = par_en && ($urandom_range(0, 5) == 0);
            bs        = ($urandom_range(0, 5) == 0);
            send_frame(d, bp, bs, -1); settle();
            expect_word("R4 R5 R13 random", exp_word(d, nine_bits), bs, bp, 0, 0);
            read_word();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule